// File: doc/BRIEF.md
# Delta-State Custom Instruction Execute Unit

This block is a functional unit for the execute stage of a 64-bit RISC-V pipeline. It holds two private 64-bit registers: a reference word and an accumulator of XOR deltas. The current state is their XOR. Four R-type instructions in the custom-0 major opcode act on them. Each one completes in the same execute cycle in which it is issued, with the same latency as an ordinary ALU XOR.

Two of the operations take the rs1 operand and write no destination register. The operation named "set" loads the reference and clears the accumulator. The operation named "merge" XORs a delta into the accumulator. The other two operations ignore rs1 and write the destination. The operation named "peek" returns the current state. The operation named "drain" returns the current state and empties the accumulator in the same edge. XOR is commutative, so producers may merge deltas in any order and the resulting state is the same.

Each issued instruction passes through three pieces of logic: a decoder, a state register and a writeback stage. The decoder maps the instruction to one operation class: none, set, merge, peek, drain or bad. The state register moves on the clock edge that ends the issue cycle. The writeback stage combines the operation class with the current state to produce the result, the write enable and the illegal flag during the issue cycle.

Top module: `delta_exec_unit`

## Requirements
- R1: After reset the reference and the accumulator are both zero, so a peek returns 0.
- R2: set (opcode 7'h0B, funct3 000, funct7 0) makes the reference equal to rs1 and clears the accumulator on the same edge. It raises no write enable, and result_o reads 0.
- R3: merge (funct3 001) XORs rs1 into the accumulator. It raises no write enable, and result_o reads 0.
- R4: peek (funct3 010) drives result_o with reference XOR accumulator in the issue cycle and changes no state.
- R5: drain (funct3 011) drives result_o with reference XOR accumulator in the issue cycle and clears the accumulator. The reference is unchanged.
- R6: peek and drain raise rd_we_o only when rd_i is nonzero. A drain with rd_i = 0 still clears the accumulator.
- R7: Under opcode 7'h0B, funct3 values 100 to 111 raise illegal_o. They change no state, raise no write enable, and result_o reads 0.
- R8: Under opcode 7'h0B, any nonzero funct7 raises illegal_o, whatever funct3 is. The instruction changes no state.
- R9: With issue_i low, or with an opcode other than 7'h0B, the unit raises no flag, raises no write enable and changes no state.
- R10: Each operation's state update is visible to the next instruction, issued in the very next cycle.
- R11: A given set of merges yields the same state in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is in the execute stage this cycle |
| opcode_i | input | 7 | Major opcode field |
| funct3_i | input | 3 | funct3 field |
| funct7_i | input | 7 | funct7 field |
| rd_i | input | 5 | Destination register index |
| rs1_val_i | input | 64 | Value of the rs1 operand |
| result_o | output | 64 | Writeback value |
| rd_we_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The bench goes after the corner cases that a plausible design would get wrong.

- **Merge before set.** A merge is followed by a set and then a peek. A design that forgot to clear the accumulator on set would return the old delta mixed into the new reference.
- **Drain to x0.** A drain with rd = x0 is followed by a peek. A design that gated the clear on the write enable would keep the delta.
- **Illegal encodings.** All four reserved funct3 codes are tried, and nonzero funct7 is tried on a merge and on a peek. A design that checked only funct3 would update state or write a register.
- **Ignored instructions.** Foreign opcodes and instructions without the issue strobe must leave the state untouched.
- **Merge order.** Permuted merge orders must give equal states.

// File: rtl/delta_pkg.sv
package delta_pkg;

    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;
    localparam int RIDX_W = 5;

    localparam logic [OPC_W-1:0] OPC_CUSTOM0 = 7'h0B;

    localparam logic [F3_W-1:0] F3_SET   = 3'b000;
    localparam logic [F3_W-1:0] F3_MERGE = 3'b001;
    localparam logic [F3_W-1:0] F3_PEEK  = 3'b010;
    localparam logic [F3_W-1:0] F3_DRAIN = 3'b011;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SET   = 3'd1,
        OP_MERGE = 3'd2,
        OP_PEEK  = 3'd3,
        OP_DRAIN = 3'd4,
        OP_BAD   = 3'd5
    } delta_op_e;

endpackage

// File: rtl/delta_decode.sv
module delta_decode
    import delta_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC = OPC_CUSTOM0
) (
    input  logic              issue_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [F3_W-1:0]   funct3_i,
    input  logic [F7_W-1:0]   funct7_i,
    output delta_op_e         op_o
);

    logic mine;

    assign mine = issue_i && (opcode_i == OPC);

    always_comb begin
        op_o = OP_NONE;
        if (mine) begin
            if (funct7_i != '0) begin
                op_o = OP_BAD;
            end else begin
                unique case (funct3_i)
                    F3_SET:   op_o = OP_SET;
                    F3_MERGE: op_o = OP_MERGE;
                    F3_PEEK:  op_o = OP_PEEK;
                    F3_DRAIN: op_o = OP_DRAIN;
                    default:  op_o = OP_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/delta_state.sv
module delta_state
    import delta_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  delta_op_e        op_i,
    input  logic [XLEN-1:0]  rs1_i,
    output logic [XLEN-1:0]  cur_o
);

    logic [XLEN-1:0] ref_q;
    logic [XLEN-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            acc_q <= '0;
        end else begin
            unique case (op_i)
                OP_SET: begin
                    ref_q <= rs1_i;
                    acc_q <= '0;
                end
                OP_MERGE: acc_q <= acc_q ^ rs1_i;
                OP_DRAIN: acc_q <= '0;
                default: ;
            endcase
        end
    end

    assign cur_o = ref_q ^ acc_q;

endmodule

// File: rtl/delta_wb.sv
module delta_wb
    import delta_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  delta_op_e          op_i,
    input  logic [RIDX_W-1:0]  rd_i,
    input  logic [XLEN-1:0]    cur_i,
    output logic [XLEN-1:0]    result_o,
    output logic               rd_we_o,
    output logic               illegal_o
);

    always_comb begin
        result_o  = '0;
        rd_we_o   = 1'b0;
        illegal_o = 1'b0;
        unique case (op_i)
            OP_PEEK, OP_DRAIN: begin
                result_o = cur_i;
                rd_we_o  = (rd_i != '0);
            end
            OP_BAD:  illegal_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/delta_exec_unit.sv
module delta_exec_unit
    import delta_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [6:0]        opcode_i,
    input  logic [2:0]        funct3_i,
    input  logic [6:0]        funct7_i,
    input  logic [4:0]        rd_i,
    input  logic [XLEN-1:0]   rs1_val_i,
    output logic [XLEN-1:0]   result_o,
    output logic              rd_we_o,
    output logic              illegal_o
);

    delta_op_e       op;
    logic [XLEN-1:0] cur;

    delta_decode #(.OPC(OPC_CUSTOM0)) i_dec (
        .issue_i  (issue_i),
        .opcode_i (opcode_i),
        .funct3_i (funct3_i),
        .funct7_i (funct7_i),
        .op_o     (op)
    );

    delta_state #(.XLEN(XLEN)) i_st (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .rs1_i (rs1_val_i),
        .cur_o (cur)
    );

    delta_wb #(.XLEN(XLEN)) i_wb (
        .op_i      (op),
        .rd_i      (rd_i),
        .cur_i     (cur),
        .result_o  (result_o),
        .rd_we_o   (rd_we_o),
        .illegal_o (illegal_o)
    );

endmodule

// File: rtl/delta_exec_checker.sv
module delta_exec_checker #(
    parameter int XLEN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_i,
    input logic [6:0]       opcode_i,
    input logic [2:0]       funct3_i,
    input logic [6:0]       funct7_i,
    input logic [4:0]       rd_i,
    input logic [XLEN-1:0]  rs1_val_i,
    input logic [XLEN-1:0]  result_o,
    input logic             rd_we_o,
    input logic             illegal_o
);

    logic ours;
    logic is_set;
    logic is_merge;
    logic is_peek;

    assign ours     = issue_i && (opcode_i == 7'h0B) && (funct7_i == 7'd0);
    assign is_set   = ours && (funct3_i == 3'b000);
    assign is_merge = ours && (funct3_i == 3'b001);
    assign is_peek  = ours && (funct3_i == 3'b010);

    assert_no_write_when_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !rd_we_o);

    assert_no_write_to_x0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (rd_i != 5'd0));

    assert_flags_need_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i || opcode_i != 7'h0B) |-> (!illegal_o && !rd_we_o));

    assert_set_merge_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_set || is_merge) |-> (!rd_we_o && !illegal_o));

    assert_funct7_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 7'h0B && funct7_i != 7'd0) |-> illegal_o);

    assert_set_then_peek_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_peek && $past(is_set)) |-> (result_o == $past(rs1_val_i)));

    assert_peek_twice_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_peek && $past(is_peek)) |-> $stable(result_o));

endmodule

bind delta_exec_unit delta_exec_checker #(.XLEN(XLEN)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (issue_i),
    .opcode_i  (opcode_i),
    .funct3_i  (funct3_i),
    .funct7_i  (funct7_i),
    .rd_i      (rd_i),
    .rs1_val_i (rs1_val_i),
    .result_o  (result_o),
    .rd_we_o   (rd_we_o),
    .illegal_o (illegal_o)
);

// File: tb/test_delta_exec_unit.sv
module test_delta_exec_unit;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_i = 1'b0;
    logic [6:0]      opcode_i = '0;
    logic [2:0]      funct3_i = '0;
    logic [6:0]      funct7_i = '0;
    logic [4:0]      rd_i = '0;
    logic [XLEN-1:0] rs1_val_i = '0;
    logic [XLEN-1:0] result_o;
    logic            rd_we_o;
    logic            illegal_o;

    always #10 clk = ~clk;

    delta_exec_unit #(.XLEN(XLEN)) i_delta_exec_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_i),
        .opcode_i  (opcode_i),
        .funct3_i  (funct3_i),
        .funct7_i  (funct7_i),
        .rd_i      (rd_i),
        .rs1_val_i (rs1_val_i),
        .result_o  (result_o),
        .rd_we_o   (rd_we_o),
        .illegal_o (illegal_o)
    );

    typedef struct {
        logic [XLEN-1:0] res;
        logic            we;
        logic            ill;
        string           req;
    } exp_t;

    exp_t            sb[$];
    int              checks = 0;
    int              errors = 0;
    logic [XLEN-1:0] m_ref = '0;
    logic [XLEN-1:0] m_acc = '0;
    logic [XLEN-1:0] peek_a;
    bit              done = 1'b0;

    // Driver: present one instruction per cycle and queue what the requirements predict.
    task automatic drive(input logic iss, input logic [6:0] opc, input logic [2:0] f3,
                         input logic [6:0] f7, input logic [4:0] rd,
                         input logic [XLEN-1:0] v, input string req);
        exp_t e;
        @(negedge clk);
        #1;
        issue_i = iss; opcode_i = opc; funct3_i = f3; funct7_i = f7;
        rd_i = rd; rs1_val_i = v;
        e.res = '0; e.we = 1'b0; e.ill = 1'b0; e.req = req;
        if (iss && opc == 7'h0B) begin
            if (f7 != 7'd0 || f3[2]) begin
                e.ill = 1'b1;
            end else if (f3 == 3'b000) begin
                m_ref = v; m_acc = '0;
            end else if (f3 == 3'b001) begin
                m_acc = m_acc ^ v;
            end else begin
                e.res = m_ref ^ m_acc;
                e.we  = (rd != 5'd0);
                if (f3 == 3'b011) m_acc = '0;
            end
        end
        sb.push_back(e);
    endtask

    task automatic op(input logic [2:0] f3, input logic [4:0] rd,
                      input logic [XLEN-1:0] v, input string req);
        drive(1'b1, 7'h0B, f3, 7'd0, rd, v, req);
    endtask

    // Monitor: compare outputs in the middle of the issue cycle.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (result_o !== e.res || rd_we_o !== e.we || illegal_o !== e.ill) begin
                    errors++;
                    $display("FAIL %s: got res=%h we=%b ill=%b, expected res=%h we=%b ill=%b",
                             e.req, result_o, rd_we_o, illegal_o, e.res, e.we, e.ill);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        op(3'b010, 5'd1, '0, "R1 reset peek");
        // R2 set, R10 back to back
        op(3'b000, 5'd5, 64'hDEAD_BEEF_0123_4567, "R2 set no write");
        op(3'b010, 5'd2, '0, "R2 R10 peek after set");
        // R3 merge
        op(3'b001, 5'd3, 64'h0000_0000_0000_00FF, "R3 merge no write");
        op(3'b001, 5'd3, 64'hF0F0_0000_0000_0000, "R3 merge again");
        op(3'b010, 5'd4, '0, "R3 R10 peek after merges");
        op(3'b010, 5'd4, '0, "R4 peek leaves state");
        // R5 drain
        op(3'b011, 5'd7, '0, "R5 drain result");
        op(3'b010, 5'd8, '0, "R5 peek after drain");
        // R6 drain to x0 still clears
        op(3'b001, 5'd3, 64'h1234, "R6 merge");
        op(3'b011, 5'd0, '0, "R6 drain to x0");
        op(3'b010, 5'd9, '0, "R6 peek after x0 drain");
        op(3'b010, 5'd0, '0, "R6 peek to x0 no write");
        // R2 set clears pending delta
        op(3'b001, 5'd1, 64'hAAAA_5555_AAAA_5555, "R2 merge before set");
        op(3'b000, 5'd1, 64'h0BAD_F00D_CAFE_0001, "R2 set");
        op(3'b010, 5'd1, '0, "R2 peek shows only new ref");
        // R7 reserved funct3
        op(3'b001, 5'd1, 64'h0000_FFFF_0000_0001, "R7 merge");
        for (int k = 4; k < 8; k++) op(3'(k), 5'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R7 reserved funct3");
        op(3'b010, 5'd1, '0, "R7 state untouched");
        // R8 nonzero funct7
        drive(1'b1, 7'h0B, 3'b001, 7'h20, 5'd1, 64'h77, "R8 funct7 merge illegal");
        drive(1'b1, 7'h0B, 3'b010, 7'h01, 5'd1, '0, "R8 funct7 peek illegal");
        drive(1'b1, 7'h0B, 3'b000, 7'h40, 5'd1, 64'h99, "R8 funct7 set illegal");
        op(3'b010, 5'd1, '0, "R8 state untouched");
        // R9 foreign opcode and no issue
        drive(1'b1, 7'h33, 3'b001, 7'd0, 5'd2, 64'h5555, "R9 foreign opcode");
        drive(1'b0, 7'h0B, 3'b000, 7'd0, 5'd2, 64'h6666, "R9 no issue set");
        drive(1'b0, 7'h0B, 3'b011, 7'd0, 5'd2, '0, "R9 no issue drain");
        drive(1'b1, 7'h2B, 3'b100, 7'h7F, 5'd2, '0, "R9 foreign opcode odd fields");
        op(3'b010, 5'd1, '0, "R9 state untouched");
        // R11 order independence
        op(3'b000, 5'd1, 64'h1111_2222_3333_4444, "R11 set");
        op(3'b001, 5'd1, 64'h00FF_00FF_00FF_00FF, "R11 merge x");
        op(3'b001, 5'd1, 64'h8000_0000_0000_0001, "R11 merge y");
        op(3'b001, 5'd1, 64'h0123_4567_89AB_CDEF, "R11 merge z");
        op(3'b010, 5'd1, '0, "R11 peek order xyz");
        peek_a = m_ref ^ m_acc;
        op(3'b000, 5'd1, 64'h1111_2222_3333_4444, "R11 set again");
        op(3'b001, 5'd1, 64'h0123_4567_89AB_CDEF, "R11 merge z");
        op(3'b001, 5'd1, 64'h00FF_00FF_00FF_00FF, "R11 merge x");
        op(3'b001, 5'd1, 64'h8000_0000_0000_0001, "R11 merge y");
        op(3'b010, 5'd1, '0, "R11 peek order zxy");
        // Bench-side check that the two orders agree (against fixed arithmetic).
        checks++;
        if (peek_a !== (64'h1111_2222_3333_4444 ^ 64'h00FF_00FF_00FF_00FF ^
                        64'h8000_0000_0000_0001 ^ 64'h0123_4567_89AB_CDEF)) begin
            errors++;
            $display("FAIL R11 model: got %h, expected fixed xor", peek_a);
        end
        drive(1'b0, 7'd0, 3'd0, 7'd0, 5'd0, '0, "R9 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule